// File: doc/BRIEF.md
# Supply-Good Power-Up Sequencer

This block decides when the chip's supplies may be treated as settled. Once the low-power domain reports that it has power, a delay counter counts a fixed number of clock cycles. When the count completes, the terminal flag is combined with a live main-domain voltage-OK flag to form `supply_good`, which the reset manager uses to release device reset. The same delay runs again every time the device leaves a low-power mode.

The block also conditions the raw low-voltage detector flags. A detector that is powered down reads as good. The detector that watches the 5 V rail can be masked by a control bit. The results are combined into one status bit. A small synchronous register port holds that mask bit, plus a 4-bit reference trim value. The trim value loads from the device-option inputs only while the second reset phase is active.

A clocked power-on-reset latch is also included. It releases when the supply passes the power-on threshold. It re-arms whenever the main detector reports that the supply has fallen below its lower threshold.

Top module: `pwr_seq_top`

## Requirements
- R1: While `lp_dom_pwr` is low, the delay counter is held at zero and `supply_good` is low; dropping `lp_dom_pwr` clears `supply_good` by the next clock edge.
- R2: `supply_good` rises after exactly `DELAY_CYC` rising clock edges at which `lp_dom_pwr` is high (with `main_dom_ok` high), and then stays high; the counter saturates and does not wrap.
- R3: `supply_good` equals end-of-count AND `main_dom_ok`. It falls in the same cycle that `main_dom_ok` falls, and returns as soon as `main_dom_ok` returns, with no new count.
- R4: A clock edge with `lp_exit` high restarts the count. `supply_good` is low after that edge and rises again `DELAY_CYC` edges later.
- R5: A detector whose `det_pd` bit is high shows `det_eff` high, whatever its raw `det_ok`.
- R6: When the mask bit is set (register address 0, bit 0), detector index `LVD5_IDX` (default 1) reads as good. `det_all_ok` is the AND of all `det_eff` bits, and the mask affects no other detector.
- R7: The trim value (register address 1, bits 3:0) loads `opt_trim` at each clock edge where `rst_phase2` is high, and holds at all other edges.
- R8: `por_active` is high after reset. It falls at the first edge where `vdd_above_por` is high and the main detector (index 0) reads good. It rises again at any edge where the main detector's `det_eff` is low.
- R9: Reading address 0 returns the mask in bit 0, and reading address 1 returns the trim in bits 3:0; all other bits and addresses read zero. Writes to address 1 have no effect.
- R10: After reset, `supply_good` is 0, `por_active` is 1, and the mask and trim are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_dom_pwr | input | 1 | Low-power domain is powered |
| main_dom_ok | input | 1 | Main-domain voltage OK |
| lp_exit | input | 1 | Low-power-mode exit event (one cycle) |
| det_ok | input | N_DET | Raw detector OK flags (index 0 = main supply) |
| det_pd | input | N_DET | Detector power-down controls |
| vdd_above_por | input | 1 | Supply above the power-on release threshold |
| rst_phase2 | input | 1 | Reset phase 2 active |
| opt_trim | input | TRIM_W | Device-option trim value |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| det_eff | output | N_DET | Conditioned detector flags |
| det_all_ok | output | 1 | AND of conditioned detector flags |
| lvd5_mask | output | 1 | Current 5 V detector mask bit |
| trim_val | output | TRIM_W | Current trim value |
| por_active | output | 1 | Power-on reset asserted |
| supply_good | output | 1 | Supply-good for the reset manager |

## Verification
The bench samples `supply_good` one edge before and exactly at the terminal count, both after power-up and after a low-power exit. An off-by-one counter, or one that fails to restart, would then move the rising edge. It drops `main_dom_ok` while the count is saturated and checks the output within the same cycle. A registered gate would lag by one cycle, and a counter that wraps would lose supply-good again. The trim field is driven with a new option value outside reset phase 2, and is also written through the register port. A latch that is not gated by the phase, or one that software can write, would change the value that reads back. The mask is shown to cover only its own detector, and a powered-down main detector is shown not to re-arm the power-on latch.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
   localparam int unsigned ADDR_W    = 2;
   localparam int unsigned DATA_W    = 8;
   localparam int unsigned TRIM_W    = 4;
   localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] A_TRIM = 2'd1;
   localparam int unsigned MASK_BIT  = 0;
endpackage

// File: rtl/pwr_seq_delay.sv
module pwr_seq_delay #(
   parameter int unsigned DELAY_CYC = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lp_pwr,
   input  logic lp_exit,
   output logic eoc
);
   localparam int unsigned CW = $clog2(DELAY_CYC + 1);
   localparam logic [CW-1:0] TERM = CW'(DELAY_CYC);

   logic [CW-1:0] cnt;

   if (DELAY_CYC < 2) begin : g_bad_delay
      $error("DELAY_CYC must be at least 2");
   end

   assign eoc = (cnt == TERM);

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt <= '0;
      else if (!lp_pwr || lp_exit) cnt <= '0;
      else if (!eoc)              cnt <= cnt + 1'b1;
   end

   AST_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !lp_pwr |=> !eoc); // R1
   AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc && lp_pwr && !lp_exit) |=> eoc); // R2
   AST_RISE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc) |-> $past(lp_pwr)); // R2
   AST_EXIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      lp_exit |=> !eoc); // R4
endmodule

// File: rtl/pwr_seq_det.sv
module pwr_seq_det #(
   parameter int unsigned N_DET    = 3,
   parameter int unsigned LVD5_IDX = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_DET-1:0] det_ok,
   input  logic [N_DET-1:0] det_pd,
   input  logic             mask,
   output logic [N_DET-1:0] det_eff,
   output logic             all_ok
);
   for (genvar i = 0; i < N_DET; i++) begin : g_det
      if (i == LVD5_IDX) begin : g_maskable
         assign det_eff[i] = det_ok[i] | det_pd[i] | mask;
      end else begin : g_plain
         assign det_eff[i] = det_ok[i] | det_pd[i];
      end
   end

   assign all_ok = &det_eff;

   AST_PD_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      (det_pd == {N_DET{1'b1}}) |-> all_ok); // R5
   AST_MASK_ONLY_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!det_ok[0] && !det_pd[0]) |-> !all_ok); // R6
endmodule

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
   import pwr_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              phase2,
   input  logic [TRIM_W-1:0] opt_trim,
   output logic              mask,
   output logic [TRIM_W-1:0] trim
);
   if (DATA_W < TRIM_W) begin : g_bad_width
      $error("register data narrower than trim field");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask <= 1'b0;
         trim <= '0;
      end else begin
         if (we && addr == A_CTRL) mask <= wdata[MASK_BIT];
         if (phase2)               trim <= opt_trim;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTRL:  rdata[MASK_BIT] = mask;
         A_TRIM:  rdata[TRIM_W-1:0] = trim;
         default: rdata = '0;
      endcase
   end

   AST_TRIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !phase2 |=> $stable(trim)); // R7
   AST_TRIM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      phase2 |=> trim == $past(opt_trim)); // R7
   AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_CTRL) |=> mask == $past(wdata[MASK_BIT])); // R6
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
   import pwr_seq_pkg::*;
#(
   parameter int unsigned DELAY_CYC = 256,
   parameter int unsigned N_DET     = 3,
   parameter int unsigned LVD5_IDX  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lp_dom_pwr,
   input  logic              main_dom_ok,
   input  logic              lp_exit,
   input  logic [N_DET-1:0]  det_ok,
   input  logic [N_DET-1:0]  det_pd,
   input  logic              vdd_above_por,
   input  logic              rst_phase2,
   input  logic [TRIM_W-1:0] opt_trim,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [N_DET-1:0]  det_eff,
   output logic              det_all_ok,
   output logic              lvd5_mask,
   output logic [TRIM_W-1:0] trim_val,
   output logic              por_active,
   output logic              supply_good
);
   localparam int unsigned MAIN_IDX = 0;

   if (N_DET < 2 || LVD5_IDX >= N_DET || LVD5_IDX == MAIN_IDX) begin : g_bad_det
      $error("detector count or 5 V detector index out of range");
   end

   logic eoc;
   logic por_rel;

   pwr_seq_delay #(.DELAY_CYC(DELAY_CYC)) u_delay (
      .clk(clk), .rst_n(rst_n), .lp_pwr(lp_dom_pwr), .lp_exit(lp_exit), .eoc(eoc)
   );

   pwr_seq_det #(.N_DET(N_DET), .LVD5_IDX(LVD5_IDX)) u_det (
      .clk(clk), .rst_n(rst_n), .det_ok(det_ok), .det_pd(det_pd),
      .mask(lvd5_mask), .det_eff(det_eff), .all_ok(det_all_ok)
   );

   pwr_seq_regs u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .phase2(rst_phase2), .opt_trim(opt_trim),
      .mask(lvd5_mask), .trim(trim_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                     por_rel <= 1'b0;
      else if (!det_eff[MAIN_IDX])    por_rel <= 1'b0;
      else if (vdd_above_por)         por_rel <= 1'b1;
   end

   assign por_active  = ~por_rel;
   assign supply_good = eoc & main_dom_ok;

   AST_POR_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      !det_eff[MAIN_IDX] |=> por_active); // R8
   AST_POR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (vdd_above_por && det_eff[MAIN_IDX]) |=> !por_active); // R8
   AST_GOOD_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      lp_exit |=> !supply_good); // R4
   AST_GOOD_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
      !lp_dom_pwr |=> !supply_good); // R1
endmodule

// File: tb/pwr_seq_top_test.sv
module pwr_seq_top_test;
   localparam int CLK_PERIOD = 10;
   localparam int DLY = 256;
   localparam int ND = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lp_dom_pwr = 1'b0, main_dom_ok = 1'b1, lp_exit = 1'b0;
   logic [ND-1:0] det_ok = '1, det_pd = '0;
   logic vdd_above_por = 1'b0, rst_phase2 = 1'b0;
   logic [3:0] opt_trim = 4'h0;
   logic reg_we = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [ND-1:0] det_eff;
   logic det_all_ok, lvd5_mask, por_active, supply_good;
   logic [3:0] trim_val;

   int n_chk = 0, n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_seq_top #(.DELAY_CYC(DLY), .N_DET(ND), .LVD5_IDX(1)) uut (
      .clk(clk), .rst_n(rst_n), .lp_dom_pwr(lp_dom_pwr), .main_dom_ok(main_dom_ok),
      .lp_exit(lp_exit), .det_ok(det_ok), .det_pd(det_pd), .vdd_above_por(vdd_above_por),
      .rst_phase2(rst_phase2), .opt_trim(opt_trim), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .det_eff(det_eff), .det_all_ok(det_all_ok),
      .lvd5_mask(lvd5_mask), .trim_val(trim_val), .por_active(por_active),
      .supply_good(supply_good)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      tick(1);
      reg_we = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [1:0] a, input logic [7:0] exp);
      reg_addr = a; #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic t_reset;
      check("R10 supply_good", supply_good, 0);
      check("R10 por_active", por_active, 1);
      check("R10 mask", lvd5_mask, 0);
      check("R10 trim", trim_val, 0);
      tick(3);
      check("R1 unpowered", supply_good, 0);
   endtask

   task automatic t_powerup;
      lp_dom_pwr = 1'b1;
      tick(DLY - 1);
      check("R2 one edge early", supply_good, 0);
      tick(1);
      check("R2 at terminal", supply_good, 1);
      tick(20);
      check("R2 saturate", supply_good, 1);
   endtask

   task automatic t_main_gate;
      main_dom_ok = 1'b0; #1;
      check("R3 same-cycle drop", supply_good, 0);
      tick(2);
      main_dom_ok = 1'b1; #1;
      check("R3 immediate return", supply_good, 1);
   endtask

   task automatic t_lp_exit;
      lp_exit = 1'b1;
      tick(1);
      lp_exit = 1'b0;
      check("R4 low after exit", supply_good, 0);
      tick(DLY - 1);
      check("R4 one edge early", supply_good, 0);
      tick(1);
      check("R4 recount done", supply_good, 1);
      lp_dom_pwr = 1'b0;
      tick(1);
      check("R1 power lost", supply_good, 0);
   endtask

   task automatic t_detectors;
      det_ok[1] = 1'b0; #1;
      check("R6 unmasked low", det_all_ok, 0);
      wr(2'd0, 8'h01);
      check("R6 masked all_ok", det_all_ok, 1);
      check("R6 masked eff", det_eff[1], 1);
      rd_check("R9 read ctrl", 2'd0, 8'h01);
      det_ok[1] = 1'b1; det_ok[2] = 1'b0; #1;
      check("R6 mask not on idx2", det_all_ok, 0);
      det_pd[2] = 1'b1; #1;
      check("R5 pd forces good", det_eff[2], 1);
      check("R5 all_ok with pd", det_all_ok, 1);
      det_pd[2] = 1'b0; det_ok[2] = 1'b1;
      wr(2'd0, 8'h00);
      rd_check("R9 ctrl cleared", 2'd0, 8'h00);
   endtask

   task automatic t_trim;
      opt_trim = 4'hA;
      tick(1);
      rd_check("R7 no load outside phase2", 2'd1, 8'h00);
      rst_phase2 = 1'b1;
      tick(1);
      rst_phase2 = 1'b0;
      rd_check("R7 load in phase2", 2'd1, 8'h0A);
      opt_trim = 4'h5;
      tick(2);
      rd_check("R7 hold", 2'd1, 8'h0A);
      wr(2'd1, 8'hFF);
      rd_check("R9 trim not writable", 2'd1, 8'h0A);
      rd_check("R9 unused addr", 2'd3, 8'h00);
   endtask

   task automatic t_por;
      check("R8 active before vdd", por_active, 1);
      vdd_above_por = 1'b1;
      tick(1);
      check("R8 released", por_active, 0);
      det_pd[0] = 1'b1; det_ok[0] = 1'b0;
      tick(2);
      check("R5 pd main no rearm", por_active, 0);
      det_pd[0] = 1'b0;
      tick(1);
      check("R8 rearmed", por_active, 1);
      det_ok[0] = 1'b1;
      tick(1);
      check("R8 re-released", por_active, 0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 50000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_powerup();
      t_main_gate();
      t_lp_exit();
      t_detectors();
      t_trim();
      t_por();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule